// File: doc/BRIEF.md
# Phase Current Unbalance Supervisor

This block guards a three-phase current measuring circuit against faults such as an open or shorted transformer lead. Every clock it takes three unsigned current magnitudes and picks the largest and smallest of the phases in use. It then tests whether their spread, taken as a fraction of the largest, is above a set fraction. The test uses cross-multiplication, so the datapath has no divider. When the unbalance persists for a programmed number of 10 ms ticks, a warning flag goes high.

A two-bit mode turns supervision off, limits it to phases A and B, or covers all three phases. The two-phase mode suits installations with current transformers in only two phases. When the largest current in use is below a minimum, the check is held off, so a de-energized feeder does not look unbalanced. The delay counter starts again from zero whenever the unbalance clears. The all-ones delay code means the warning never asserts.

Top module: `phase_unbal_sup`

## Requirements
- R1: Mode code 2'b00 (off) and the spare code 2'b11 disable supervision: the warning stays low for any currents.
- R2: Mode code 2'b01 uses only phases A and B, and the phase C magnitude has no effect on the warning.
- R3: Mode code 2'b10 uses phases A, B and C for the largest and smallest magnitude.
- R4: Unbalance is present when (Imax - Imin) * 20 > k * Imax, with k the threshold code in steps of 0.05. Equality is not unbalance.
- R5: Threshold codes below 5 act as 5 (0.25), and codes above 10 act as 10 (0.50).
- R6: While Imax of the phases in use is below the parameter MIN_CUR, no unbalance is detected.
- R7: With delay code D (ticks of 10 ms), the warning rises one clock after the tick that brings the count of ticks during a continuous unbalance to D. With D = 0, it rises two clocks after the unbalanced inputs are applied.
- R8: When the unbalance clears, the warning falls within two clocks and the tick count restarts from zero.
- R9: The all-ones delay code means infinity: the warning never asserts. The tick count saturates at all ones and does not wrap.
- R10: While synchronous reset is high, and in the cycle after it, the warning is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse every 10 ms |
| mode_i | input | 2 | Supervision mode: 00 off, 01 A and B, 10 A, B and C, 11 off |
| thr_code_i | input | 4 | Threshold code k (valid 5..10, fraction k*0.05) |
| delay_i | input | DLY_W | Delay in ticks; all ones means infinity |
| ia_i | input | MAG_W | Phase A magnitude |
| ib_i | input | MAG_W | Phase B magnitude |
| ic_i | input | MAG_W | Phase C magnitude |
| warn_o | output | 1 | Measuring-circuit unbalance warning |

## Verification
The bench builds the block with MAG_W = 10, DLY_W = 8 and MIN_CUR = 40. The 8-bit delay puts the infinity code (255) and counter saturation within a few hundred ticks. The 10-bit magnitudes allow exact equality cases at the 0.25 and 0.50 limits. The small minimum current lets the bench probe just below and at the energization limit.

// File: rtl/unbal_pkg.sv
package unbal_pkg;

    typedef enum logic [1:0] {
        SUP_OFF = 2'b00,
        SUP_AB  = 2'b01,
        SUP_ABC = 2'b10,
        SUP_RSV = 2'b11
    } sup_mode_e;

    localparam int NPH      = 3;
    localparam int K_W      = 4;
    localparam int K_LO     = 5;
    localparam int K_HI     = 10;
    localparam int K_SCALE  = 20;
    localparam int SCALE_W  = 5;

    typedef struct packed {
        logic use_a;
        logic use_b;
        logic use_c;
    } phase_use_t;

    function automatic logic [NPH-1:0] phase_mask(input sup_mode_e m);
        case (m)
            SUP_AB:  return 3'b011;
            SUP_ABC: return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic [K_W-1:0] clamp_k(input logic [K_W-1:0] k);
        if (k < K_W'(K_LO)) return K_W'(K_LO);
        if (k > K_W'(K_HI)) return K_W'(K_HI);
        return k;
    endfunction

endpackage

// File: rtl/unbal_extrema.sv
module unbal_extrema
    import unbal_pkg::*;
#(
    parameter int MAG_W = 16
) (
    input  logic [NPH-1:0][MAG_W-1:0] mag_i,
    input  logic [NPH-1:0]            use_i,
    output logic [MAG_W-1:0]          max_o,
    output logic [MAG_W-1:0]          min_o
);

    logic [NPH-1:0][MAG_W-1:0] max_masked;
    logic [NPH-1:0][MAG_W-1:0] min_masked;

    genvar g;
    generate
        for (g = 0; g < NPH; g++) begin : g_ph
            assign max_masked[g] = use_i[g] ? mag_i[g] : '0;
            assign min_masked[g] = use_i[g] ? mag_i[g] : '1;
        end
    endgenerate

    always_comb begin
        logic [MAG_W-1:0] hi;
        logic [MAG_W-1:0] lo;
        hi = '0;
        lo = '1;
        for (int i = 0; i < NPH; i++) begin
            if (max_masked[i] > hi) hi = max_masked[i];
            if (min_masked[i] < lo) lo = min_masked[i];
        end
        max_o = hi;
        min_o = (use_i == '0) ? '0 : lo;
    end

    always_comb begin
        p_order_r3: assert (max_o >= min_o);
    end

endmodule

// File: rtl/unbal_ratio.sv
module unbal_ratio
    import unbal_pkg::*;
#(
    parameter int MAG_W = 16
) (
    input  logic [MAG_W-1:0] max_i,
    input  logic [MAG_W-1:0] min_i,
    input  logic [K_W-1:0]   k_i,
    output logic             unbal_o
);

    localparam int PROD_W = MAG_W + SCALE_W;

    logic [K_W-1:0]    k_eff;
    logic [MAG_W-1:0]  spread;
    logic [PROD_W-1:0] lhs;
    logic [PROD_W-1:0] rhs;

    assign k_eff   = clamp_k(k_i);
    assign spread  = max_i - min_i;
    assign lhs     = PROD_W'(spread) * PROD_W'(K_SCALE);
    assign rhs     = PROD_W'(k_eff) * PROD_W'(max_i);
    assign unbal_o = lhs > rhs;

endmodule

// File: rtl/unbal_timer.sv
module unbal_timer #(
    parameter int DLY_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             cond_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             warn_o
);

    localparam logic [DLY_W-1:0] CNT_TOP = '1;

    logic [DLY_W-1:0] cnt_q;
    logic             warn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            warn_q <= 1'b0;
        end else begin
            if (!cond_i)
                cnt_q <= '0;
            else if (tick_i && cnt_q != CNT_TOP)
                cnt_q <= cnt_q + 1'b1;
            warn_q <= cond_i && (dly_i != CNT_TOP) && (cnt_q >= dly_i);
        end
    end

    assign warn_o = warn_q;

    p_warn_needs_cond_r7: assert property (@(posedge clk) disable iff (rst)
        warn_q |-> $past(cond_i));

    p_clear_restart_r8: assert property (@(posedge clk) disable iff (rst)
        !cond_i |=> cnt_q == '0);

    p_infinite_r9: assert property (@(posedge clk) disable iff (rst)
        dly_i == CNT_TOP |=> !warn_q);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (cond_i && cnt_q == CNT_TOP) |=> cnt_q == CNT_TOP);

endmodule

// File: rtl/phase_unbal_sup.sv
module phase_unbal_sup
    import unbal_pkg::*;
#(
    parameter int MAG_W   = 16,
    parameter int DLY_W   = 14,
    parameter int MIN_CUR = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [1:0]       mode_i,
    input  logic [K_W-1:0]   thr_code_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic [MAG_W-1:0] ia_i,
    input  logic [MAG_W-1:0] ib_i,
    input  logic [MAG_W-1:0] ic_i,
    output logic             warn_o
);

    localparam logic [MAG_W-1:0] MIN_MAG = MAG_W'(MIN_CUR);

    sup_mode_e                 mode;
    phase_use_t                use_s;
    logic [NPH-1:0][MAG_W-1:0] mags;
    logic [MAG_W-1:0]          imax;
    logic [MAG_W-1:0]          imin;
    logic                      unbal;
    logic                      cond_d;
    logic                      cond_q;

    assign mode  = sup_mode_e'(mode_i);
    assign use_s = phase_use_t'({<<{phase_mask(mode)}});
    assign mags  = {ic_i, ib_i, ia_i};

    unbal_extrema #(.MAG_W(MAG_W)) u_ext (
        .mag_i (mags),
        .use_i ({use_s.use_c, use_s.use_b, use_s.use_a}),
        .max_o (imax),
        .min_o (imin)
    );

    unbal_ratio #(.MAG_W(MAG_W)) u_ratio (
        .max_i   (imax),
        .min_i   (imin),
        .k_i     (thr_code_i),
        .unbal_o (unbal)
    );

    assign cond_d = (mode == SUP_AB || mode == SUP_ABC) && (imax >= MIN_MAG) && unbal;

    always_ff @(posedge clk) begin
        if (rst) cond_q <= 1'b0;
        else     cond_q <= cond_d;
    end

    unbal_timer #(.DLY_W(DLY_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .cond_i (cond_q),
        .dly_i  (delay_i),
        .warn_o (warn_o)
    );

    p_mode_off_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b00 || mode_i == 2'b11) |=> !cond_q);

    p_low_current_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b01 && ia_i < MIN_MAG && ib_i < MIN_MAG) |=> !cond_q);

    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> !warn_o);

endmodule

// File: tb/test_phase_unbal_sup.sv
module test_phase_unbal_sup;

    localparam int MAG_W = 10;
    localparam int DLY_W = 8;
    localparam int MIN_C = 40;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick = 1'b0;
    logic [1:0]       mode = 2'b00;
    logic [3:0]       thr = 4'd5;
    logic [DLY_W-1:0] dly = '0;
    logic [MAG_W-1:0] ia = '0, ib = '0, ic = '0;
    logic             warn;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    phase_unbal_sup #(.MAG_W(MAG_W), .DLY_W(DLY_W), .MIN_CUR(MIN_C)) i_phase_unbal_sup (
        .clk(clk), .rst(rst), .tick_i(tick), .mode_i(mode), .thr_code_i(thr),
        .delay_i(dly), .ia_i(ia), .ib_i(ib), .ic_i(ic), .warn_o(warn)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s warn=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic apply(input logic [1:0] m, input logic [3:0] k, input logic [DLY_W-1:0] d,
                         input int a, input int b, input int c);
        mode = m; thr = k; dly = d;
        ia = MAG_W'(a); ib = MAG_W'(b); ic = MAG_W'(c);
    endtask

    task automatic balance_settle();
        apply(2'b10, 4'd5, '0, 400, 400, 400);
        clks(3);
    endtask

    task automatic t_reset();
        clks(3);
        check("R10 in reset", warn, 1'b0);
        rst = 1'b0;
        clks(1);
        check("R10 after reset", warn, 1'b0);
    endtask

    task automatic t_modes_off();
        apply(2'b00, 4'd5, '0, 400, 0, 0);
        clks(3);
        check("R1 mode off", warn, 1'b0);
        apply(2'b11, 4'd5, '0, 400, 0, 0);
        clks(3);
        check("R1 spare mode", warn, 1'b0);
    endtask

    task automatic t_two_phase();
        apply(2'b01, 4'd5, '0, 400, 400, 0);
        clks(3);
        check("R2 C ignored", warn, 1'b0);
        apply(2'b01, 4'd5, '0, 400, 200, 400);
        clks(2);
        check("R2 A-B unbalance", warn, 1'b1);
        balance_settle();
    endtask

    task automatic t_three_phase();
        apply(2'b10, 4'd5, '0, 400, 400, 0);
        clks(1);
        check("R7 zero delay one clock", warn, 1'b0);
        clks(1);
        check("R3 C used, R7 zero delay", warn, 1'b1);
        balance_settle();
        check("R8 cleared", warn, 1'b0);
    endtask

    task automatic t_limits();
        apply(2'b10, 4'd5, '0, 400, 300, 350);
        clks(3);
        check("R4 equality k5", warn, 1'b0);
        apply(2'b10, 4'd5, '0, 400, 299, 350);
        clks(3);
        check("R4 above k5", warn, 1'b1);
        apply(2'b10, 4'd10, '0, 400, 200, 300);
        clks(3);
        check("R4 equality k10", warn, 1'b0);
        apply(2'b10, 4'd2, '0, 400, 320, 400);
        clks(3);
        check("R5 low code clamps", warn, 1'b0);
        apply(2'b10, 4'd15, '0, 400, 180, 400);
        clks(3);
        check("R5 high code clamps", warn, 1'b1);
        balance_settle();
    endtask

    task automatic t_min_current();
        apply(2'b01, 4'd5, '0, 39, 0, 0);
        clks(3);
        check("R6 below minimum", warn, 1'b0);
        apply(2'b01, 4'd5, '0, 40, 0, 0);
        clks(3);
        check("R6 at minimum", warn, 1'b1);
        balance_settle();
    endtask

    task automatic t_delay();
        apply(2'b10, 4'd5, 8'd3, 400, 100, 400);
        clks(2);
        ticks(2);
        check("R7 before delay", warn, 1'b0);
        ticks(1);
        check("R7 at count edge", warn, 1'b0);
        clks(1);
        check("R7 after delay", warn, 1'b1);
        apply(2'b10, 4'd5, 8'd3, 400, 400, 400);
        clks(2);
        check("R8 falls", warn, 1'b0);
        apply(2'b10, 4'd5, 8'd3, 400, 100, 400);
        clks(2);
        ticks(2);
        clks(1);
        check("R8 count restarted", warn, 1'b0);
        balance_settle();
    endtask

    task automatic t_infinite();
        apply(2'b10, 4'd5, 8'd255, 400, 100, 400);
        clks(2);
        ticks(300);
        clks(1);
        check("R9 infinity", warn, 1'b0);
        dly = 8'd254;
        clks(2);
        check("R9 saturated count", warn, 1'b1);
        balance_settle();
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_modes_off();
                t_two_phase();
                t_three_phase();
                t_limits();
                t_min_current();
                t_delay();
                t_infinite();
            end
            begin
                #(8 * 200000);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule